// File: doc/BRIEF.md
# Parallel Code-Flash Programming Sequencer

This block is the device-side controller that an external programmer talks to when it loads a 4 KB on-chip code flash in parallel. The programmer puts a 12-bit address on two inputs: a low byte and a high nibble. It selects an operation on a 4-bit mode input and strobes an active-low program pulse. For byte and lock writes the block latches the operands and times the operation itself. It drops a ready output while the operation runs. The address and data inputs are then free.

Read modes give back stored code, or a fixed identification byte, on a registered data output with an output-enable. While a byte write is still running, a read of that same address returns the written data with bit 7 inverted. Software on the programmer can therefore poll the data bus instead of the ready pin. A chip erase needs a long low pulse. It sweeps the whole array and the lock bits back to ones. Write time and erase pulse width are parameters, so simulation can use short values.

Top module: `flash_prog_seq`

## Requirements
- R1: The byte address is {addr_hi, addr_lo} (4096 bytes, 000h–FFFh). In verify mode (mode_sel = 4'hC), the byte stored at that address appears on data_out, with data_oe high, one clock after the address and mode are sampled.
- R2: In write mode (mode_sel = 4'hE), the first clock edge that samples prog_n low after a high sample starts a byte write, provided the block is ready. ready is low from that edge for exactly WRITE_CYC clock cycles.
- R3: When a byte write completes, the stored byte becomes the old byte AND the new byte, so no bit goes from 0 to 1 without an erase.
- R4: A verify read of the address being written, while the write runs, returns the written byte with bit 7 inverted and bits 6:0 unchanged. After ready returns high, the same read returns the stored byte.
- R5: A program pulse that arrives while ready is low is ignored. The running operation ends on its original schedule, and the second address is not written.
- R6: In erase mode (mode_sel = 4'h8), ERASE_PULSE consecutive low samples of prog_n start a chip erase. ready is then low for 4096 cycles, and afterwards every byte reads FFh and all lock bits are unprogrammed. A shorter low pulse has no effect.
- R7: In lock mode (mode_sel = 4'hF), a program pulse programs each lock bit whose data_in bit is 1. Bit 0 is lock 1, bit 1 is lock 2, bit 2 is lock 3. The timing is the same as R2.
- R8: While lock 1 or lock 2 is programmed, verify reads return FFh. Lock 3 alone does not block verify.
- R9: In signature mode (mode_sel = 4'h0), addresses 030h, 031h and 032h read 1Eh, 51h, and FFh (VPP_HIGH = 1) or 05h (VPP_HIGH = 0). Every other address reads 00h.
- R10: During and after reset, ready is high, data_oe is low, data_out is 00h and the lock bits are unprogrammed.
- R11: data_oe is high one clock after mode_sel is sampled as verify or signature, and low one clock after any other mode is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_lo | input | 8 | Address bits 7:0 |
| addr_hi | input | ADDR_W-8 | Address bits 11:8 |
| mode_sel | input | 4 | Operation select |
| prog_n | input | 1 | Active-low program pulse |
| data_in | input | 8 | Write data or lock-bit mask |
| data_out | output | 8 | Registered read data |
| data_oe | output | 1 | Drive enable for data_out |
| ready | output | 1 | High when no write or erase is running |

## Verification
Read results are due one clock after the address and mode are sampled. The bench's driver stamps each expected byte with the cycle count of the next rising edge. The monitor compares it at the falling edge after that cycle is reached. A byte or lock write makes ready fall on the edge that samples the pulse and rise WRITE_CYC edges later. An erase makes ready fall on the ERASE_PULSE-th low sample and rise 4096 edges later. Ready is checked on the last busy cycle and on the first ready cycle, so a window that is one cycle too short or too long is caught. The polling read is placed in the first busy cycle, where the inverted bit 7 must still be present.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    MODE_SIG    = 4'h0,
    MODE_ERASE  = 4'h8,
    MODE_VERIFY = 4'hC,
    MODE_WRITE  = 4'hE,
    MODE_LOCK   = 4'hF
  } fmode_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } opstate_e;

  // A cell only moves from 1 to 0 on a write.
  function automatic logic [7:0] merge_byte(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Status byte returned while a write is still running.
  function automatic logic [7:0] poll_byte(input logic [7:0] wr_b);
    return {~wr_b[7], wr_b[6:0]};
  endfunction

  function automatic logic [7:0] sig_byte(input logic [31:0] a, input logic hv);
    case (a)
      32'h030: return 8'h1E;
      32'h031: return 8'h51;
      32'h032: return hv ? 8'hFF : 8'h05;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra0,
  output logic [DATA_W-1:0] rd0,
  input  logic [ADDR_W-1:0] ra1,
  output logic [DATA_W-1:0] rd1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
  end

  assign rd0 = cells[ra0];
  assign rd1 = cells[ra1];
endmodule

// File: rtl/flash_pulse_detect.sv
module flash_pulse_detect #(
  parameter int ERASE_PULSE = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  output logic fall,
  output logic long_hit
);
  localparam int CNT_W = $clog2(ERASE_PULSE + 1);

  logic             prog_q;
  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prog_q <= prog_n;
      if (prog_n)                               low_cnt <= '0;
      else if (low_cnt != CNT_W'(ERASE_PULSE))  low_cnt <= low_cnt + 1'b1;
    end
  end

  assign fall     = prog_q & ~prog_n;
  assign long_hit = ~prog_n && (low_cnt == CNT_W'(ERASE_PULSE - 1));

  // A held pulse strobes the erase trigger once.
  p_hit_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    long_hit |=> !long_hit);
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              long_hit,
  input  logic [3:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic              busy,
  output logic              poll_live,
  output logic              read_open,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [7:0]        lat_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wa,
  output logic              erase_wr
);
  localparam int TW = (WRITE_CYC > 1) ? $clog2(WRITE_CYC) : 1;

  opstate_e          state;
  logic [TW-1:0]     cnt;
  logic [ADDR_W-1:0] eaddr;
  logic              lat_lock;
  logic [2:0]        lock_q;

  logic start_w, start_e, commit, erase_last;

  assign start_w    = fall && (mode_sel == MODE_WRITE || mode_sel == MODE_LOCK) && state == OP_IDLE;
  assign start_e    = long_hit && mode_sel == MODE_ERASE && state == OP_IDLE;
  assign commit     = state == OP_PROG && cnt == '0;
  assign erase_last = state == OP_ERASE && eaddr == {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= OP_IDLE;
      cnt      <= '0;
      eaddr    <= '0;
      lat_addr <= '0;
      lat_data <= '0;
      lat_lock <= 1'b0;
      lock_q   <= 3'b111;
    end else begin
      case (state)
        OP_IDLE: begin
          if (start_w) begin
            state    <= OP_PROG;
            cnt      <= TW'(WRITE_CYC - 1);
            lat_addr <= addr;
            lat_data <= data_in;
            lat_lock <= (mode_sel == MODE_LOCK);
          end else if (start_e) begin
            state <= OP_ERASE;
            eaddr <= '0;
          end
        end
        OP_PROG: begin
          if (commit) begin
            state <= OP_IDLE;
            if (lat_lock) lock_q <= lock_q & ~lat_data[2:0];
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        OP_ERASE: begin
          if (erase_last) begin
            state  <= OP_IDLE;
            lock_q <= 3'b111;
          end else begin
            eaddr <= eaddr + 1'b1;
          end
        end
        default: state <= OP_IDLE;
      endcase
    end
  end

  assign busy      = state != OP_IDLE;
  assign poll_live = state == OP_PROG && !lat_lock;
  assign read_open = lock_q[0] & lock_q[1];
  assign erase_wr  = state == OP_ERASE;
  assign mem_we    = (commit && !lat_lock) || erase_wr;
  assign mem_wa    = erase_wr ? eaddr : lat_addr;

  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall || long_hit));
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fall) |=> ($stable(lat_addr) && $stable(lat_data)));
  p_lock_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(erase_last) |-> ((lock_q & ~$past(lock_q)) == 3'b000));
  p_erase_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_last |=> (lock_q == 3'b111 && !busy));
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter bit VPP_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        rd_byte,
  input  logic              poll_live,
  input  logic              read_open,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [7:0]        lat_data,
  output logic [7:0]        data_out,
  output logic              data_oe
);
  logic       poll_hit;
  logic [7:0] nxt_out;
  logic       nxt_oe;

  assign poll_hit = poll_live && addr == lat_addr;

  always_comb begin
    nxt_out = 8'h00;
    nxt_oe  = 1'b0;
    case (mode_sel)
      MODE_VERIFY: begin
        nxt_oe = 1'b1;
        if (poll_hit)       nxt_out = poll_byte(lat_data);
        else if (read_open) nxt_out = rd_byte;
        else                nxt_out = 8'hFF;
      end
      MODE_SIG: begin
        nxt_oe  = 1'b1;
        nxt_out = sig_byte(32'(addr), VPP_HIGH);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_out <= 8'h00;
      data_oe  <= 1'b0;
    end else begin
      data_out <= nxt_out;
      data_oe  <= nxt_oe;
    end
  end

  p_poll_bit7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_sel == MODE_VERIFY && poll_hit) |-> (data_out[7] == ~$past(lat_data[7])));
  p_locked_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_sel == MODE_VERIFY && !poll_hit && !read_open) |-> (data_out == 8'hFF));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WRITE_CYC   = 24,
  parameter int ERASE_PULSE = 20,
  parameter bit VPP_HIGH    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr_lo,
  input  logic [ADDR_W-9:0] addr_hi,
  input  logic [3:0]        mode_sel,
  input  logic              prog_n,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe,
  output logic              ready
);
  logic [ADDR_W-1:0] addr, lat_addr, mem_wa;
  logic [7:0]        lat_data, rd_byte, old_byte, mem_wd;
  logic              fall, long_hit, busy, poll_live, read_open, mem_we, erase_wr;

  assign addr = {addr_hi, addr_lo};

  flash_pulse_detect #(.ERASE_PULSE(ERASE_PULSE)) u_pulse (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .fall(fall), .long_hit(long_hit)
  );

  flash_op_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall(fall), .long_hit(long_hit),
    .mode_sel(mode_sel), .addr(addr), .data_in(data_in),
    .busy(busy), .poll_live(poll_live), .read_open(read_open),
    .lat_addr(lat_addr), .lat_data(lat_data),
    .mem_we(mem_we), .mem_wa(mem_wa), .erase_wr(erase_wr)
  );

  assign mem_wd = erase_wr ? 8'hFF : merge_byte(old_byte, lat_data);

  flash_cell_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
    .ra0(addr), .rd0(rd_byte), .ra1(lat_addr), .rd1(old_byte)
  );

  flash_read_path #(.ADDR_W(ADDR_W), .VPP_HIGH(VPP_HIGH)) u_read (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .addr(addr), .rd_byte(rd_byte),
    .poll_live(poll_live), .read_open(read_open), .lat_addr(lat_addr), .lat_data(lat_data),
    .data_out(data_out), .data_oe(data_oe)
  );

  assign ready = ~busy;

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (ready && !data_oe && data_out == 8'h00));
endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WC    = 12;
  localparam int EP    = 8;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam logic [3:0] M_SIG = 4'h0, M_ERASE = 4'h8, M_VER = 4'hC, M_WR = 4'hE, M_LOCK = 4'hF;

  logic clk = 1'b0, rst_n = 1'b0, prog_n = 1'b1, data_oe, ready;
  logic [7:0] addr_lo = 8'h0, data_in = 8'h0, data_out;
  logic [3:0] addr_hi = 4'h0, mode_sel = 4'h2;

  flash_prog_seq #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_PULSE(EP), .VPP_HIGH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .addr_hi(addr_hi), .mode_sel(mode_sel),
    .prog_n(prog_n), .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  typedef struct { logic [7:0] exp; int due; string tag; } sb_t;
  sb_t sbq[$];
  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compare each expected read once its edge has passed.
  always @(negedge clk) begin
    sb_t e;
    if (sbq.size() > 0 && sbq[0].due <= cyc) begin
      e = sbq.pop_front();
      check(data_oe === 1'b1 && data_out === e.exp, e.tag, {data_oe, data_out}, {1'b1, e.exp});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_addr(input logic [11:0] a);
    addr_lo = a[7:0];
    addr_hi = a[11:8];
  endtask

  // Driver: present a read and queue its expected byte.
  task automatic read_exp(input logic [11:0] a, input logic [3:0] m, input logic [7:0] exp, input string tag);
    sb_t e;
    mode_sel = m;
    set_addr(a);
    e.exp = exp; e.due = cyc + 1; e.tag = tag;
    sbq.push_back(e);
    tick();
  endtask

  task automatic start_pulse(input logic [3:0] m, input logic [11:0] a, input logic [7:0] d);
    mode_sel = m; set_addr(a); data_in = d; prog_n = 1'b0;
    tick();
    prog_n = 1'b1;
  endtask

  // Byte or lock write with full busy-window check; optional poll in first busy cycle.
  task automatic write_op(input logic [3:0] m, input logic [11:0] a, input logic [7:0] d,
                          input bit poll, input string tag);
    start_pulse(m, a, d);
    check(ready == 1'b0, tag, ready, 0);
    if (poll) read_exp(a, M_VER, {~d[7], d[6:0]}, "R4 poll");
    else tick();
    repeat (WC - 2) tick();
    check(ready == 1'b0, tag, ready, 0);
    tick();
    check(ready == 1'b1, tag, ready, 1);
  endtask

  task automatic chip_erase();
    mode_sel = M_ERASE; prog_n = 1'b0;
    repeat (EP) tick();
    prog_n = 1'b1;
    check(ready == 1'b0, "R6 erase start", ready, 0);
    repeat (DEPTH - 1) tick();
    check(ready == 1'b0, "R6 erase last busy", ready, 0);
    tick();
    check(ready == 1'b1, "R6 erase done", ready, 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) tick();
    check(ready == 1'b1 && data_oe == 1'b0 && data_out == 8'h00, "R10 in reset", {ready, data_oe, data_out}, 9'h100);
    rst_n = 1'b1;
    tick();
    check(ready == 1'b1 && data_oe == 1'b0 && data_out == 8'h00, "R10 after reset", {ready, data_oe, data_out}, 9'h100);

    // R6: erase then blank reads
    chip_erase();
    read_exp(12'h000, M_VER, 8'hFF, "R6 blank 000");
    read_exp(12'hFFF, M_VER, 8'hFF, "R6 blank FFF");
    read_exp(12'h123, M_VER, 8'hFF, "R1 blank 123");

    // R2/R4: write with poll, then true data
    write_op(M_WR, 12'h123, 8'hA5, 1'b1, "R2 write busy window");
    read_exp(12'h123, M_VER, 8'hA5, "R4 true data");
    read_exp(12'h122, M_VER, 8'hFF, "R1 neighbour");

    // R3: write to a non-blank byte merges with AND
    write_op(M_WR, 12'h123, 8'h3C, 1'b1, "R3 second write");
    read_exp(12'h123, M_VER, 8'h24, "R3 and-merge");

    // R5: pulse while busy is ignored
    start_pulse(M_WR, 12'h200, 8'h11);
    check(ready == 1'b0, "R5 first start", ready, 0);
    repeat (2) tick();
    start_pulse(M_WR, 12'h300, 8'h00);
    repeat (WC - 4) tick();
    check(ready == 1'b0, "R5 original last busy", ready, 0);
    tick();
    check(ready == 1'b1, "R5 no extension", ready, 1);
    read_exp(12'h300, M_VER, 8'hFF, "R5 second not written");
    read_exp(12'h200, M_VER, 8'h11, "R1 first written");

    // R6: short erase pulse does nothing
    mode_sel = M_ERASE; prog_n = 1'b0;
    repeat (EP - 1) tick();
    prog_n = 1'b1;
    tick();
    check(ready == 1'b1, "R6 short pulse", ready, 1);
    repeat (3) tick();
    check(ready == 1'b1, "R6 short pulse later", ready, 1);
    read_exp(12'h200, M_VER, 8'h11, "R6 short pulse kept data");

    // R9: signature bytes
    read_exp(12'h030, M_SIG, 8'h1E, "R9 sig 030");
    read_exp(12'h031, M_SIG, 8'h51, "R9 sig 031");
    read_exp(12'h032, M_SIG, 8'hFF, "R9 sig 032");
    read_exp(12'h033, M_SIG, 8'h00, "R9 sig other");

    // R11: output enable follows the mode
    mode_sel = M_WR; tick(); tick();
    check(data_oe == 1'b0, "R11 oe off", data_oe, 0);
    mode_sel = M_VER; tick();
    check(data_oe == 1'b1, "R11 oe on", data_oe, 1);

    // R7/R8: lock 3 alone does not block, lock 1 does
    write_op(M_LOCK, 12'h000, 8'h04, 1'b0, "R7 lock3 timing");
    read_exp(12'h123, M_VER, 8'h24, "R8 lock3 open");
    write_op(M_LOCK, 12'h000, 8'h01, 1'b0, "R7 lock1 timing");
    read_exp(12'h123, M_VER, 8'hFF, "R8 lock1 blocks");
    read_exp(12'h200, M_VER, 8'hFF, "R8 lock1 blocks 200");
    read_exp(12'h031, M_SIG, 8'h51, "R9 sig under lock");

    // R6: erase clears array and locks
    chip_erase();
    read_exp(12'h123, M_VER, 8'hFF, "R6 erased 123");
    read_exp(12'h200, M_VER, 8'hFF, "R6 erased 200");
    write_op(M_WR, 12'h055, 8'h7E, 1'b0, "R2 write after erase");
    read_exp(12'h055, M_VER, 8'h7E, "R6 locks cleared");

    mode_sel = 4'h2;
    repeat (4) tick();
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    finish_run();
  end
endmodule